// File: doc/BRIEF.md
# Byte/Word Add-Subtract-Compare Unit with Condition Flags

This combinational unit is the arithmetic core of a small 16-bit processor's execute stage. It takes a destination value and a source value, an operation select and an operand size, and returns the arithmetic result together with four condition flags (zero, sign, carry/borrow, signed overflow) and a write-enable that tells the register or memory stage whether the destination must be updated.

Three operations are supported. Addition and subtraction both write their result back to the destination. Compare computes the subtraction only to produce flags and never asserts the write-enable. In byte mode only the low eight bits of each operand take part, and every flag is taken from bit 7. In word mode the full sixteen bits take part, and every flag is taken from bit 15.

Top module: `addsub_flag_unit`

## Requirements
- R1: With opSel=2'b00 (add), result equals dstVal+srcVal modulo the operand width and dstWrEn is 1.
- R2: With opSel=2'b01 (subtract), result equals dstVal-srcVal modulo the operand width and dstWrEn is 1.
- R3: With opSel=2'b10 (compare), dstWrEn is 0 and result and flags equal those of subtract on the same operands.
- R4: zeroFlag is 1 exactly when the operation-width result is zero.
- R5: signFlag equals the most significant bit of the operation-width result (bit 7 in byte mode, bit 15 in word mode).
- R6: For add, carryFlag is 1 exactly when the unsigned sum does not fit in the operand width.
- R7: For subtract and compare, carryFlag is 1 exactly when srcVal is unsigned-greater than dstVal at the operand width (a borrow into the MSB).
- R8: ovfFlag is 1 exactly when the signed result is out of range: for add, equal-signed operands giving a result of the other sign; for subtract and compare, operands of different sign giving a result whose sign differs from dstVal.
- R9: With wordMode=0 (byte), result[15:8] is 0 and the upper bytes of both operands have no effect on result or flags.
- R10: With opSel=2'b11 (reserved), result is 0, dstWrEn is 0 and all four flags are 0.
- R11: Byte add of 73h and 40h gives B3h with zero 0, sign 1, carry 0, overflow 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 2 | 00 add, 01 subtract, 10 compare, 11 reserved |
| wordMode | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| dstVal | input | 16 | Destination operand (left-hand input) |
| srcVal | input | 16 | Source operand |
| result | output | 16 | Arithmetic result, upper byte zero in byte mode |
| dstWrEn | output | 1 | Destination must be written with result |
| zeroFlag | output | 1 | Result is zero |
| signFlag | output | 1 | Result MSB |
| carryFlag | output | 1 | Carry out (add) or borrow in (subtract/compare) |
| ovfFlag | output | 1 | Signed overflow |

## Verification
On every evaluation the assertions confirm that compare and the reserved code never write, that the reserved code leaves all outputs zero, that byte mode clears the upper result byte, that zero and sign agree with the visible result, and that the borrow matches an unsigned magnitude comparison done apart from the adder. Exact result values, add carry, the signed overflow cases, the 73h+40h example and the insensitivity of byte mode to upper operand bytes are shown only by the bench's vectors, which pair chosen operands with hand-computed outcomes.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_CMP = 2'b10,
    OP_NONE = 2'b11
  } arithOp_e;

  typedef struct packed {
    logic doSub;
    logic wrEn;
    logic flagEn;
  } arithCtrl_t;
endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic [1:0] opSel,
  output arithCtrl_t ctrl
);
  arithOp_e opCode;
  assign opCode = arithOp_e'(opSel);

  always_comb begin
    ctrl = '0;
    unique case (opCode)
      OP_ADD: begin ctrl.wrEn = 1'b1; ctrl.flagEn = 1'b1; end
      OP_SUB: begin ctrl.doSub = 1'b1; ctrl.wrEn = 1'b1; ctrl.flagEn = 1'b1; end
      OP_CMP: begin ctrl.doSub = 1'b1; ctrl.flagEn = 1'b1; end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/addsub_dp.sv
module addsub_dp
  import addsub_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  arithCtrl_t        ctrl,
  input  logic              wordMode,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcVal,
  output logic [DATA_W-1:0] result,
  output logic              zeroFlag,
  output logic              signFlag,
  output logic              carryFlag,
  output logic              ovfFlag
);
  localparam int NUM_LANES = 2;

  logic [DATA_W-1:0] bOp;
  logic [DATA_W-1:0] laneRes  [NUM_LANES];
  logic              laneCout [NUM_LANES];
  logic              laneOvf  [NUM_LANES];
  logic              laneSign [NUM_LANES];

  assign bOp = ctrl.doSub ? ~srcVal : srcVal;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int W = (g == 0) ? BYTE_W : DATA_W;
    logic [W:0] sumExt;
    assign sumExt = {1'b0, dstVal[W-1:0]} + {1'b0, bOp[W-1:0]}
                  + {{W{1'b0}}, ctrl.doSub};
    assign laneRes[g]  = DATA_W'(sumExt[W-1:0]);
    assign laneCout[g] = sumExt[W];
    assign laneSign[g] = sumExt[W-1];
    assign laneOvf[g]  = (dstVal[W-1] == bOp[W-1]) && (sumExt[W-1] != dstVal[W-1]);
  end

  logic laneSel;
  assign laneSel = wordMode;

  always_comb begin
    result    = '0;
    zeroFlag  = 1'b0;
    signFlag  = 1'b0;
    carryFlag = 1'b0;
    ovfFlag   = 1'b0;
    if (ctrl.flagEn) begin
      result    = laneSel ? laneRes[1] : laneRes[0];
      signFlag  = laneSel ? laneSign[1] : laneSign[0];
      ovfFlag   = laneSel ? laneOvf[1] : laneOvf[0];
      carryFlag = (laneSel ? laneCout[1] : laneCout[0]) ^ ctrl.doSub;
      zeroFlag  = (result == '0);
    end
  end

  always_comb begin
    if (!wordMode) begin
      p_upper_zero_r9: assert (result[DATA_W-1:BYTE_W] == '0)
        else $error("R9 upper result byte not zero in byte mode");
    end
  end
endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
  import addsub_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [1:0]        opSel,
  input  logic              wordMode,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcVal,
  output logic [DATA_W-1:0] result,
  output logic              dstWrEn,
  output logic              zeroFlag,
  output logic              signFlag,
  output logic              carryFlag,
  output logic              ovfFlag
);
  arithCtrl_t ctrl;

  addsub_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  addsub_dp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
    .ctrl      (ctrl),
    .wordMode  (wordMode),
    .dstVal    (dstVal),
    .srcVal    (srcVal),
    .result    (result),
    .zeroFlag  (zeroFlag),
    .signFlag  (signFlag),
    .carryFlag (carryFlag),
    .ovfFlag   (ovfFlag)
  );

  assign dstWrEn = ctrl.wrEn;

  logic [DATA_W-1:0] dstMask, srcMask;
  logic              msbView;
  assign dstMask = wordMode ? dstVal : {{(DATA_W-BYTE_W){1'b0}}, dstVal[BYTE_W-1:0]};
  assign srcMask = wordMode ? srcVal : {{(DATA_W-BYTE_W){1'b0}}, srcVal[BYTE_W-1:0]};
  assign msbView = wordMode ? result[DATA_W-1] : result[BYTE_W-1];

  always_comb begin
    if (opSel == 2'b10) begin
      p_cmp_nowrite_r3: assert (!dstWrEn) else $error("R3 compare wrote destination");
    end
    if (opSel == 2'b11) begin
      p_idle_quiet_r10: assert (!dstWrEn && !zeroFlag && !signFlag && !carryFlag && !ovfFlag
                                && result == '0)
        else $error("R10 reserved code produced activity");
    end else begin
      p_zero_match_r4: assert (zeroFlag == (result == '0)) else $error("R4 zero flag mismatch");
      p_sign_match_r5: assert (signFlag == msbView) else $error("R5 sign flag mismatch");
    end
    if (opSel == 2'b01 || opSel == 2'b10) begin
      p_borrow_r7: assert (carryFlag == (srcMask > dstMask)) else $error("R7 borrow mismatch");
    end
  end
endmodule

// File: tb/addsub_flag_unit_tb.sv
module addsub_flag_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  opSel;
  logic        wordMode;
  logic [15:0] dstVal, srcVal, result;
  logic        dstWrEn, zeroFlag, signFlag, carryFlag, ovfFlag;

  addsub_flag_unit dut_i (
    .opSel(opSel), .wordMode(wordMode), .dstVal(dstVal), .srcVal(srcVal),
    .result(result), .dstWrEn(dstWrEn), .zeroFlag(zeroFlag), .signFlag(signFlag),
    .carryFlag(carryFlag), .ovfFlag(ovfFlag)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // {op, wordMode, dst, src, expResult, expWr, expZ, expS, expC, expO}
  localparam logic [55:0] VEC [12] = '{
    {2'd0, 1'b0, 16'h0073, 16'h0040, 16'h00B3, 1'b1, 4'b0101}, // R11 R1 R8
    {2'd0, 1'b0, 16'hFF80, 16'h5580, 16'h0000, 1'b1, 4'b1011}, // R9 R6 R4
    {2'd0, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 4'b0101}, // R8 R5
    {2'd0, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 4'b1010}, // R6 R4
    {2'd1, 1'b1, 16'h7FFF, 16'h8000, 16'hFFFF, 1'b1, 4'b0111}, // R2 R7 R8
    {2'd1, 1'b0, 16'h0005, 16'h0003, 16'h0002, 1'b1, 4'b0000}, // R2
    {2'd1, 1'b0, 16'h1203, 16'h3405, 16'h00FE, 1'b1, 4'b0110}, // R7 R9
    {2'd2, 1'b1, 16'h1234, 16'h1234, 16'h0000, 1'b0, 4'b1000}, // R3 R4
    {2'd2, 1'b0, 16'h0080, 16'h0001, 16'h007F, 1'b0, 4'b0001}, // R3 R8
    {2'd3, 1'b1, 16'h1234, 16'h1111, 16'h0000, 1'b0, 4'b0000}, // R10
    {2'd0, 1'b1, 16'h8000, 16'h8000, 16'h0000, 1'b1, 4'b1011}, // R6 R8
    {2'd1, 1'b1, 16'h0000, 16'h0001, 16'hFFFF, 1'b1, 4'b0110}  // R7 R5
  };

  task automatic applyAndCheck(input logic [1:0] op, input logic wm,
                               input logic [15:0] d, input logic [15:0] s,
                               input logic [15:0] expRes, input logic expWr,
                               input logic [3:0] expFlags, input string req);
    @(negedge clk);
    opSel = op; wordMode = wm; dstVal = d; srcVal = s;
    @(posedge clk);
    #1;
    checks++;
    if (result !== expRes || dstWrEn !== expWr ||
        {zeroFlag, signFlag, carryFlag, ovfFlag} !== expFlags) begin
      errors++;
      $display("FAIL %s: got res=%h wr=%b zscO=%b expected res=%h wr=%b zscO=%b",
               req, result, dstWrEn, {zeroFlag, signFlag, carryFlag, ovfFlag},
               expRes, expWr, expFlags);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    opSel = 2'd0; wordMode = 1'b0; dstVal = '0; srcVal = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // state after reset with idle inputs: add of zeros, R4 zero set
    applyAndCheck(2'd0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'b1000, "R4 reset");
    for (int i = 0; i < 12; i++) begin
      applyAndCheck(VEC[i][55:54], VEC[i][53], VEC[i][52:37], VEC[i][36:21],
                    VEC[i][20:5], VEC[i][4], VEC[i][3:0], $sformatf("R1-vec%0d", i));
    end
    // R9: upper operand bytes ignored, sweep of upper bytes
    for (int k = 0; k < 8; k++) begin
      applyAndCheck(2'd1, 1'b0, {8'(k * 37), 8'h10}, {8'(k * 91), 8'h20},
                    16'h00F0, 1'b1, 4'b0110, "R9 upper ignored");
    end
    // R3: compare matches subtract except write-enable
    applyAndCheck(2'd2, 1'b1, 16'h0003, 16'h8000, 16'h8003, 1'b0, 4'b0111, "R3 cmp");
    applyAndCheck(2'd1, 1'b1, 16'h0003, 16'h8000, 16'h8003, 1'b1, 4'b0111, "R2 sub");
    // R10: reserved in byte mode
    applyAndCheck(2'd3, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b0, 4'b0000, "R10 byte");
    // R11 repeated with junk upper bytes
    applyAndCheck(2'd0, 1'b0, 16'hAA73, 16'h5540, 16'h00B3, 1'b1, 4'b0101, "R11");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule